// File: doc/BRIEF.md
# Guarded Page Attribute Table

This block remembers which memory pages carry the guarded attribute used for branch-target checking. Software-visible control logic issues range commands. A set command marks pages as guarded and a clear command removes the mark. Each command gives a byte base address and a byte length. The block walks the range one 4 KiB page per clock cycle and updates a small fully associative table of page keys. A page key is the address with its top eight tag bits dropped, shifted down by the page size. Every address inside one page therefore resolves to the same entry.

Two lookup ports answer whether a page is guarded. The first port takes an explicit address, or falls back to the current program counter when no address is supplied. The second port always looks up the program counter. A global guard-all input overrides the table and makes every page read as guarded. Redundant sets, redundant clears, table overflow and badly aligned commands are reported as one-cycle pulses.

Top module: `guard_page_table`

## Requirements
- R1: The page key is address bits 55:12. Bits 63:56 (tag) and bits 11:0 (offset) have no effect on any lookup, so all addresses of a page give the same answer.
- R2: After reset the table is empty: with guard_all low both lookup outputs read 0, and cmd_busy, cmd_reject, warn_dup, warn_absent and full_err are all 0.
- R3: A command whose base or length has a nonzero value in bits 11:0 is rejected. This applies to set (cmd_op=0) and to clear (cmd_op=1). cmd_reject pulses for the one cycle after acceptance, cmd_busy stays 0, and the table is left unchanged.
- R4: An aligned command covering N>0 pages keeps cmd_busy high for exactly N cycles, starting the cycle after acceptance. It processes consecutive page keys, one per cycle, starting at the base key. After a set, every page in the range reads guarded and the pages on either side are unaffected.
- R5: Setting a page that is already guarded stores no second entry and gives one warn_dup pulse for that page.
- R6: A clear removes every guarded page in its range. Each page in the range that was not guarded gives one warn_absent pulse.
- R7: While guard_all is 1, both lookup outputs read 1 whatever the table holds.
- R8: When q_has_addr is 0, q_guarded answers for the page of pc and ignores q_addr.
- R9: The table holds 16 pages. Setting a new page while all 16 entries are in use gives one full_err pulse and leaves that page not guarded.
- R10: An aligned command with zero length is accepted and does nothing: no busy, no pulse and no table change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request; taken when cmd_busy is 0 |
| cmd_op | input | 1 | 0 = set guarded, 1 = clear guarded |
| cmd_base | input | 64 | Byte base address of the range (tag bits ignored) |
| cmd_len | input | 32 | Byte length of the range |
| cmd_busy | output | 1 | High while range pages are being processed |
| cmd_reject | output | 1 | Pulse: command misaligned and dropped |
| warn_dup | output | 1 | Pulse: a page in a set range was already guarded |
| warn_absent | output | 1 | Pulse: a page in a clear range was not guarded |
| full_err | output | 1 | Pulse: a new page could not be stored, table full |
| guard_all | input | 1 | Global override: every page reads guarded |
| q_has_addr | input | 1 | 1 = look up q_addr, 0 = look up pc |
| q_addr | input | 64 | Explicit lookup address |
| pc | input | 64 | Current program counter |
| q_guarded | output | 1 | Guarded status for the first lookup port |
| pc_guarded | output | 1 | Guarded status of the page holding pc |

## Verification
A corrupted key or valid bit shows up as a wrong lookup answer on the next combinational read after the clock edge that wrote it. It also shows up as a wrong warn_dup or warn_absent pulse the next time a command reaches that page. A wrong walker count shows up as a busy window of the wrong length, with pulse totals that differ from a reference model, on the same command. The random phase reuses a small pool of page keys. Because the pool is small, sets and clears keep colliding and the table fills up, so duplicate, absent and overflow cases all recur within a few commands.

// File: rtl/gpt_pkg.sv
// Package: shared types for the guarded page attribute table.
// Assumes: one-bit command opcode, set encoded as 0.
package gpt_pkg;
    typedef enum logic {
        OP_SET   = 1'b0,
        OP_CLEAR = 1'b1
    } gpt_op_e;
endpackage

// File: rtl/gpt_match.sv
// Module: compares one page key against every table entry.
// Assumes: entries are qualified by their valid bits; output is one-hot or zero
// when the table holds no duplicates.
module gpt_match #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 44
) (
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [KEY_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          hit
);
    // Per-entry comparators, one per table slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (keys[g] == key);
    end
    assign hit = |hit_vec;
endmodule

// File: rtl/gpt_entry_store.sv
// Module: key and valid-bit storage for the page table.
// Assumes: set and clear never arrive in the same cycle; a set only happens
// when free_any is high.
module gpt_entry_store #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 44
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_set,
    input  logic [KEY_W-1:0]              wr_key,
    input  logic                          wr_clr,
    input  logic [ENTRIES-1:0]            clr_vec,
    output logic [ENTRIES-1:0][KEY_W-1:0] keys,
    output logic [ENTRIES-1:0]            vld,
    output logic                          free_any
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0] free_idx;

    // Lowest-numbered empty slot finder.
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    // Entry write: allocate on set, drop matching entries on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            keys <= '0;
        end else begin
            if (wr_set) begin
                vld[free_idx]  <= 1'b1;
                keys[free_idx] <= wr_key;
            end
            if (wr_clr) begin
                vld <= vld & ~clr_vec;
            end
        end
    end

    // R9: an allocation never lands on an occupied slot.
    a_r9_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |-> !vld[free_idx]);
endmodule

// File: rtl/gpt_range_walker.sv
// Module: accepts range commands, checks alignment, steps through the pages
// and raises the write strobes and warning pulses.
// Assumes: commands offered while busy are ignored; the key counter wraps
// inside the untagged key field.
module gpt_range_walker #(
    parameter int ADDR_W    = 64,
    parameter int TAG_LSB   = 56,
    parameter int PAGE_LOG2 = 12,
    parameter int LEN_W     = 32,
    parameter int KEY_W     = TAG_LSB - PAGE_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cur_hit,
    input  logic              free_any,
    output logic              busy,
    output logic [KEY_W-1:0]  cur_key,
    output logic              wr_set,
    output logic              wr_clr,
    output logic              reject,
    output logic              warn_dup,
    output logic              warn_absent,
    output logic              full_err
);
    import gpt_pkg::*;

    localparam int CNT_W = LEN_W - PAGE_LOG2;

    logic             busy_q;
    gpt_op_e          op_q;
    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] rem_q;
    logic             accept;
    logic             aligned;
    logic [CNT_W-1:0] pages;
    logic             is_set;
    logic             is_clr;
    logic             unused_tag;

    assign unused_tag = ^cmd_base[ADDR_W-1:TAG_LSB];

    // Command decode: acceptance, alignment and page count.
    always_comb begin
        accept  = cmd_valid && !busy_q;
        aligned = (cmd_base[PAGE_LOG2-1:0] == '0) && (cmd_len[PAGE_LOG2-1:0] == '0);
        pages   = cmd_len[LEN_W-1:PAGE_LOG2];
        is_set  = busy_q && (op_q == OP_SET);
        is_clr  = busy_q && (op_q == OP_CLEAR);
        wr_set  = is_set && !cur_hit && free_any;
        wr_clr  = is_clr && cur_hit;
    end

    // Walk state: load on an aligned nonzero command, then one page per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_SET;
            key_q  <= '0;
            rem_q  <= '0;
        end else if (accept && aligned && (pages != '0)) begin
            busy_q <= 1'b1;
            op_q   <= gpt_op_e'(cmd_op);
            key_q  <= cmd_base[TAG_LSB-1:PAGE_LOG2];
            rem_q  <= pages;
        end else if (busy_q) begin
            key_q <= key_q + KEY_W'(1);
            rem_q <= rem_q - CNT_W'(1);
            if (rem_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Status pulses, registered one cycle after the page they describe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject      <= 1'b0;
            warn_dup    <= 1'b0;
            warn_absent <= 1'b0;
            full_err    <= 1'b0;
        end else begin
            reject      <= accept && !aligned;
            warn_dup    <= is_set && cur_hit;
            warn_absent <= is_clr && !cur_hit;
            full_err    <= is_set && !cur_hit && !free_any;
        end
    end

    assign busy    = busy_q;
    assign cur_key = key_q;

    // R4: busy never drops before the last page.
    a_r4_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (rem_q != CNT_W'(1))) |=> busy_q);
    // R4: the page counter is nonzero for the whole walk.
    a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q != '0));
    // R3: a rejected command never starts a walk.
    a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy_q);
endmodule

// File: rtl/guard_page_table.sv
// Module: top of the guarded page attribute table. Joins the range walker,
// the entry store and three key matchers (walker, lookup port, pc port).
// Assumes: 64-bit addresses with tag in the top byte, 4 KiB pages.
module guard_page_table #(
    parameter int ADDR_W    = 64,
    parameter int TAG_LSB   = 56,
    parameter int PAGE_LOG2 = 12,
    parameter int LEN_W     = 32,
    parameter int ENTRIES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_busy,
    output logic              cmd_reject,
    output logic              warn_dup,
    output logic              warn_absent,
    output logic              full_err,
    input  logic              guard_all,
    input  logic              q_has_addr,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [ADDR_W-1:0] pc,
    output logic              q_guarded,
    output logic              pc_guarded
);
    localparam int KEY_W = TAG_LSB - PAGE_LOG2;

    logic [ENTRIES-1:0][KEY_W-1:0] keys;
    logic [ENTRIES-1:0]            vld;
    logic                          free_any;
    logic [KEY_W-1:0]              wk_key;
    logic [ENTRIES-1:0]            wk_hit_vec;
    logic                          wk_hit;
    logic                          wr_set;
    logic                          wr_clr;
    logic [ADDR_W-1:0]             sel_addr;
    logic [1:0][KEY_W-1:0]         look_key;
    logic [1:0]                    look_hit;
    logic                          unused_bits;

    // Lookup address selection: explicit address or program counter.
    always_comb begin
        sel_addr    = q_has_addr ? q_addr : pc;
        look_key[0] = sel_addr[TAG_LSB-1:PAGE_LOG2];
        look_key[1] = pc[TAG_LSB-1:PAGE_LOG2];
    end
    assign unused_bits = ^{sel_addr[ADDR_W-1:TAG_LSB], sel_addr[PAGE_LOG2-1:0],
                           pc[ADDR_W-1:TAG_LSB], pc[PAGE_LOG2-1:0]};

    gpt_range_walker #(
        .ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .PAGE_LOG2(PAGE_LOG2),
        .LEN_W(LEN_W), .KEY_W(KEY_W)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_len(cmd_len),
        .cur_hit(wk_hit), .free_any(free_any),
        .busy(cmd_busy), .cur_key(wk_key), .wr_set(wr_set), .wr_clr(wr_clr),
        .reject(cmd_reject), .warn_dup(warn_dup), .warn_absent(warn_absent),
        .full_err(full_err)
    );

    gpt_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_set(wr_set), .wr_key(wk_key), .wr_clr(wr_clr), .clr_vec(wk_hit_vec),
        .keys(keys), .vld(vld), .free_any(free_any)
    );

    gpt_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_wk_match (
        .keys(keys), .vld(vld), .key(wk_key), .hit_vec(wk_hit_vec), .hit(wk_hit)
    );

    // Lookup matchers, one per query port.
    for (genvar p = 0; p < 2; p++) begin : g_look
        logic [ENTRIES-1:0] hv;
        gpt_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
            .keys(keys), .vld(vld), .key(look_key[p]), .hit_vec(hv), .hit(look_hit[p])
        );
    end

    assign q_guarded  = guard_all | look_hit[0];
    assign pc_guarded = guard_all | look_hit[1];

    // R5: no page key is ever stored twice.
    a_r5_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wk_hit_vec));
    // R7: override forces both ports guarded.
    a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
        guard_all |-> (q_guarded && pc_guarded));
    // R3: a reject leaves the valid bits untouched.
    a_r3_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $stable(vld));
    // R9: overflow is only reported with every slot in use.
    a_r9_full_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_err |-> (&vld));
endmodule

// File: tb/guard_page_table_tb.sv
module guard_page_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [63:0] cmd_base = '0;
    logic [31:0] cmd_len = '0;
    logic        cmd_busy, cmd_reject, warn_dup, warn_absent, full_err;
    logic        guard_all = 1'b0;
    logic        q_has_addr = 1'b1;
    logic [63:0] q_addr = '0;
    logic [63:0] pc = '0;
    logic        q_guarded, pc_guarded;

    int errors = 0;
    int checks = 0;
    bit model [longint unsigned];

    guard_page_table u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_busy(cmd_busy),
        .cmd_reject(cmd_reject), .warn_dup(warn_dup), .warn_absent(warn_absent),
        .full_err(full_err), .guard_all(guard_all), .q_has_addr(q_has_addr),
        .q_addr(q_addr), .pc(pc), .q_guarded(q_guarded), .pc_guarded(pc_guarded)
    );

    always #10 clk = ~clk;

    function automatic longint unsigned key_of(input logic [63:0] a);
        return longint'((a >> 12) & 64'h0000_0FFF_FFFF_FFFF);
    endfunction

    function automatic logic [63:0] addr_of(input longint unsigned k);
        return {$urandom_range(255, 0)} << 56 | (64'(k) << 12) | 64'($urandom_range(4095, 0));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lookup both ports for one address; bench is at a negedge here.
    task automatic look(input logic [63:0] a, input string req);
        bit exp;
        exp = guard_all || model.exists(key_of(a));
        q_has_addr = 1'b1; q_addr = a; pc = a;
        #1;
        chk(q_guarded == exp, req, q_guarded, exp);
        chk(pc_guarded == exp, req, pc_guarded, exp);
    endtask

    // Issue a command, observe pulses, compare with the model.
    task automatic run_cmd(input bit op, input logic [63:0] base, input logic [31:0] len,
                           input string req);
        int bsy, dup, abs_n, full, rej;
        int e_bsy, e_dup, e_abs, e_full, e_rej;
        longint unsigned k;
        int np;
        e_bsy = 0; e_dup = 0; e_abs = 0; e_full = 0; e_rej = 0;
        if (base[11:0] != 0 || len[11:0] != 0) e_rej = 1;
        else begin
            np = int'(len >> 12);
            e_bsy = np;
            k = key_of(base);
            for (int i = 0; i < np; i++) begin
                if (op == 1'b0) begin
                    if (model.exists(k)) e_dup++;
                    else if (model.size() >= 16) e_full++;
                    else model[k] = 1'b1;
                end else begin
                    if (model.exists(k)) model.delete(k);
                    else e_abs++;
                end
                k = (k + 1) & 64'h0000_0FFF_FFFF_FFFF;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        bsy = 0; dup = 0; abs_n = 0; full = 0; rej = 0;
        forever begin
            bsy += int'(cmd_busy); dup += int'(warn_dup); abs_n += int'(warn_absent);
            full += int'(full_err); rej += int'(cmd_reject);
            if (!cmd_busy) break;
            @(negedge clk);
        end
        chk(bsy == e_bsy, {req, " busy"}, bsy, e_bsy);
        chk(dup == e_dup, {req, " dup"}, dup, e_dup);
        chk(abs_n == e_abs, {req, " absent"}, abs_n, e_abs);
        chk(full == e_full, {req, " full"}, full, e_full);
        chk(rej == e_rej, {req, " reject"}, rej, e_rej);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(cmd_busy == 0 && cmd_reject == 0 && warn_dup == 0, "R2 flags", cmd_busy, 0);
        chk(warn_absent == 0 && full_err == 0, "R2 warn", full_err, 0);
        look(64'h0000_0000_0000_5000, "R2 empty");

        // R4 and R1: three pages from key 1 with a tag in the base
        run_cmd(1'b0, 64'hAB00_0000_0000_1000, 32'h3000, "R4 set3");
        for (int k = 0; k <= 4; k++) look(addr_of(longint'(k)), "R1 R4 range");

        // R5: overlapping set, page 3 is a duplicate
        run_cmd(1'b0, 64'h0000_0000_0000_3000, 32'h2000, "R5 dup");
        look(addr_of(4), "R5 new page");

        // R3: misaligned base, misaligned length on a clear
        run_cmd(1'b0, 64'h0000_0000_0000_7004, 32'h1000, "R3 base");
        run_cmd(1'b1, 64'h0000_0000_0000_1000, 32'h0800, "R3 len");
        look(addr_of(1), "R3 unchanged");
        look(addr_of(7), "R3 not set");

        // R10: zero length
        run_cmd(1'b0, 64'h0000_0000_0000_9000, 32'h0, "R10 zero");
        look(addr_of(9), "R10 no set");

        // R6: clear two pages, then clear one absent page
        run_cmd(1'b1, 64'h0000_0000_0000_2000, 32'h2000, "R6 clear");
        run_cmd(1'b1, 64'h1200_0000_0000_2000, 32'h1000, "R6 absent");
        look(addr_of(2), "R6 gone");
        look(addr_of(1), "R6 kept");

        // R7: override
        @(negedge clk);
        guard_all = 1'b1;
        look(addr_of(30), "R7 override");
        guard_all = 1'b0;
        look(addr_of(30), "R7 released");

        // R8: no explicit address uses pc
        q_has_addr = 1'b0; q_addr = addr_of(9); pc = addr_of(1);
        #1 chk(q_guarded == 1'b1, "R8 pc guarded", q_guarded, 1);
        q_addr = addr_of(1); pc = addr_of(9);
        #1 chk(q_guarded == 1'b0, "R8 pc unguarded", q_guarded, 0);
        q_has_addr = 1'b1;

        // R9: fill table, then overflow
        run_cmd(1'b1, 64'h0, 32'h40000, "R6 wipe");
        run_cmd(1'b0, 64'h0000_0000_0006_4000, 32'h10000, "R9 fill");
        run_cmd(1'b0, 64'h0000_0000_000C_8000, 32'h1000, "R9 overflow");
        look(addr_of(200), "R9 unrecorded");
        look(addr_of(115), "R9 last stored");
        run_cmd(1'b1, 64'h0000_0000_0006_4000, 32'h10000, "R6 empty");

        // Random mix over a small key pool
        for (int it = 0; it < 80; it++) begin
            logic [63:0] b;
            logic [31:0] l;
            b = ({32'($urandom_range(255, 0)), 32'h0} << 24) | (64'($urandom_range(39, 0)) << 12);
            l = 32'($urandom_range(4, 1)) << 12;
            if ($urandom_range(7, 0) == 0) b[3:0] = 4'h8;
            if ($urandom_range(9, 0) == 0) l = 32'h0;
            run_cmd(1'($urandom_range(1, 0)), b, l, "R4 R5 R6 R9 random");
            for (int q = 0; q < 4; q++) look(addr_of(longint'($urandom_range(44, 0))), "R1 random look");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule